// File: doc/BRIEF.md
# Half-Duplex Nibble Packet Link

This block carries variable-length packets between two chips over one shared, pulled-up, four-line data bus. The two ends take turns: each side sends exactly one packet and then hands the bus to its partner. On the inside the block has a byte-wide send port, which the block pulls bytes from, and a byte-wide receive port, which delivers one strobe per received byte. On the outside it presents the bus as three signals for an external tristate pad: the level seen on the pins, the level to drive, and an output enable. When neither side drives, the pins read all ones.

There is no framing pin. A sender marks a packet by taking all four lines from ones to zeros for one cycle. It then moves the packet one nibble per clock. The receiver finds the end of the packet from a size field in the first header byte. Every change of bus owner passes through two single-cycle turnaround steps, so the two sides never drive the lines at the same time. One parameter chooses which side owns the bus after reset. A malformed start pattern, or a size beyond what the instance supports, sends the block into a quiet error state. It leaves that state once the bus floats back to all ones.

Top module: `hdlink_core`

## Requirements
- R1: After reset the block spends one cycle with the bus released (busOe low, txReady and rxValid low). With IS_MASTER=1 it then drives 4'hF. With IS_MASTER=0 it keeps the bus released until it has received one complete packet, and it then drives 4'hF.
- R2: While it waits to send, the block drives 4'hF and keeps txReady low for as long as txValid is low. The cycle after txValid is seen high, it drives 4'h0 for exactly one cycle, with txReady high in that cycle so that the first header byte is taken.
- R3: Packet data follows the start cycle with no gap, one nibble per clock. The bytes go out in the order they were taken, and each byte is sent low nibble (bits 3:0) first. txReady is high during the high-nibble cycle of every byte except the last, and the byte present on txData in that cycle is the next one sent.
- R4: The size field is bits 4:0 of the first header byte. A packet is (size+1)*4 bytes long: 0 gives a 4-byte header-only packet and 31 gives 128 bytes. The sender stops after exactly that many bytes.
- R5: After the last nibble it sends, the block drives 4'hF for exactly one cycle, releases the bus in the next cycle, and then waits to receive with the bus released. The block never drives while its partner owns the bus.
- R6: While it waits to receive, the bus released, a change of the pins from 4'hF in one cycle to 4'h0 in the next starts reception. Nibbles are sampled from the following cycle on.
- R7: Each received byte is assembled low nibble first. It appears on rxData with a one-cycle rxValid pulse in the cycle after its high nibble was on the bus.
- R8: After the last received nibble, the block keeps the bus released for exactly two cycles and then drives 4'hF while it waits to send.
- R9: While it waits to receive, a change of the pins away from 4'hF to any value other than 4'h0 puts the block in an error state. In that state it does not drive and does not pulse rxValid. The cycle after the pins read 4'hF, it re-enters the one-cycle reset step of R1 and then takes its configured role.
- R10: A received size field above MAX_BYTES/4-1 is detected in the cycle the first header byte completes. No rxValid pulse is produced for that byte or for any later nibble, and the block recovers as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ends of the link |
| rstN | input | 1 | Asynchronous active-low reset |
| txValid | input | 1 | A packet is offered on txData and stays offered until its last byte is taken |
| txData | input | 8 | Current byte of the outgoing packet, header first |
| txReady | output | 1 | The byte on txData is taken at the coming edge |
| rxValid | output | 1 | One-cycle strobe for a received byte |
| rxData | output | 8 | Received byte |
| busIn | input | 4 | Level seen on the four shared data pins |
| busOut | output | 4 | Level to drive on the data pins |
| busOe | output | 1 | Enables the pin drivers |

## Verification
The error paths are the hardest part to reach from the ports. They exist only while the block is waiting to receive. There a legal partner never drives anything but a clean zero start followed by a valid header. To reach them, the bench acts as the partner on the pin side, waits for the turnaround after a sent packet, and then drives a partial start pattern, or a header whose size field exceeds a limit reduced through MAX_BYTES. It keeps every nibble away from all ones, so the block stays in the error state until the bench releases the pins. The slave's first-receive role needs a second instance whose send request is held high from reset, so that any early drive on the bus would show.

// File: rtl/hdlink_pkg.sv
`timescale 1ns/1ps
package hdlink_pkg;

  localparam int BUS_W = 4;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_WAIT_TX,
    ST_START,
    ST_SEND,
    ST_TA1,
    ST_TA2,
    ST_WAIT_RX,
    ST_RECV,
    ST_TA3,
    ST_TA4,
    ST_ERR
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic drvEn;    // enable pin drivers
    logic drvZero;  // drive start marker
    logic drvData;  // drive current nibble
    logic clrCnt;   // clear phase and byte counter
    logic run;      // advance one nibble
    logic txLoad;   // take a byte from txData
    logic hdrTx;    // latch size from outgoing header
    logic rxCap;    // sample a nibble from the pins
    logic rxEmit;   // publish an assembled byte
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic phase;      // 0: low nibble, 1: high nibble
    logic firstByte;
    logic lastByte;
    logic sizeBad;
    logic startFall;
    logic startBad;
    logic busHigh;
  } dpStatus_t;

endpackage

// File: rtl/hdlink_ctrl.sv
`timescale 1ns/1ps
module hdlink_ctrl
  import hdlink_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  dpStatus_t  stat,
  output ctlStrobe_t strobe,
  output logic       txReady,
  output linkState_t linkState
);

  linkState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkState <= ST_INIT;
    else       linkState <= nextState;
  end

  always_comb begin
    nextState = linkState;
    strobe    = '0;
    unique case (linkState)
      ST_INIT: begin
        nextState = IS_MASTER ? ST_WAIT_TX : ST_WAIT_RX;
      end
      ST_WAIT_TX: begin
        strobe.drvEn = 1'b1;
        if (txValid) nextState = ST_START;
      end
      ST_START: begin
        strobe.drvEn   = 1'b1;
        strobe.drvZero = 1'b1;
        strobe.txLoad  = 1'b1;
        strobe.hdrTx   = 1'b1;
        strobe.clrCnt  = 1'b1;
        nextState      = ST_SEND;
      end
      ST_SEND: begin
        strobe.drvEn   = 1'b1;
        strobe.drvData = 1'b1;
        strobe.run     = 1'b1;
        if (stat.phase) begin
          if (stat.lastByte) nextState = ST_TA1;
          else               strobe.txLoad = 1'b1;
        end
      end
      ST_TA1: begin
        strobe.drvEn = 1'b1;
        nextState    = ST_TA2;
      end
      ST_TA2: nextState = ST_WAIT_RX;
      ST_WAIT_RX: begin
        strobe.clrCnt = 1'b1;
        if (stat.startFall)     nextState = ST_RECV;
        else if (stat.startBad) nextState = ST_ERR;
      end
      ST_RECV: begin
        strobe.run   = 1'b1;
        strobe.rxCap = 1'b1;
        if (stat.phase) begin
          if (stat.firstByte && stat.sizeBad) begin
            nextState = ST_ERR;
          end else begin
            strobe.rxEmit = 1'b1;
            if (stat.lastByte) nextState = ST_TA3;
          end
        end
      end
      ST_TA3: nextState = ST_TA4;
      ST_TA4: nextState = ST_WAIT_TX;
      ST_ERR: begin
        if (stat.busHigh) nextState = ST_INIT;
      end
      default: nextState = ST_INIT;
    endcase
  end

  assign txReady = strobe.txLoad;

endmodule

// File: rtl/hdlink_dpath.sv
`timescale 1ns/1ps
module hdlink_dpath
  import hdlink_pkg::*;
#(
  parameter int SIZE_W     = 5,
  parameter int WORD_BYTES = 4,
  parameter int MAX_BYTES  = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [7:0]       txData,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic             rxValid,
  output logic [7:0]       rxData,
  output dpStatus_t        stat
);

  localparam int MAX_SIZE = MAX_BYTES / WORD_BYTES - 1;
  localparam int CNT_W    = (MAX_BYTES > 2) ? $clog2(MAX_BYTES) : 1;

  logic             phase;
  logic [CNT_W-1:0] byteCnt;
  logic [SIZE_W-1:0] sizeReg;
  logic [7:0]       txShift;
  logic [BUS_W-1:0] rxLow;
  logic [BUS_W-1:0] prevIn;
  logic [7:0]       rxByte;
  int               lastIdx;

  assign rxByte  = {busIn, rxLow};
  assign lastIdx = (int'(sizeReg) + 1) * WORD_BYTES - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      byteCnt <= '0;
      sizeReg <= '0;
      txShift <= '0;
      rxLow   <= '0;
      prevIn  <= '1;
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      prevIn  <= busIn;
      rxValid <= 1'b0;

      if (strobe.clrCnt) begin
        phase   <= 1'b0;
        byteCnt <= '0;
      end else if (strobe.run) begin
        phase <= ~phase;
        if (phase) byteCnt <= byteCnt + 1'b1;
      end

      if (strobe.txLoad)   txShift <= txData;
      else if (strobe.run) txShift <= txShift >> BUS_W;

      if (strobe.hdrTx)
        sizeReg <= txData[SIZE_W-1:0];
      else if (strobe.rxCap && phase && byteCnt == '0)
        sizeReg <= rxByte[SIZE_W-1:0];

      if (strobe.rxCap && !phase) rxLow <= busIn;

      if (strobe.rxEmit) begin
        rxValid <= 1'b1;
        rxData  <= rxByte;
      end
    end
  end

  always_comb begin
    busOe = strobe.drvEn;
    if (strobe.drvZero)      busOut = '0;
    else if (strobe.drvData) busOut = txShift[BUS_W-1:0];
    else                     busOut = '1;
  end

  always_comb begin
    stat.phase     = phase;
    stat.firstByte = (byteCnt == '0);
    stat.lastByte  = (int'(byteCnt) == lastIdx);
    stat.sizeBad   = (int'(rxByte[SIZE_W-1:0]) > MAX_SIZE);
    stat.startFall = (prevIn == '1) && (busIn == '0);
    stat.startBad  = (prevIn == '1) && (busIn != '1) && (busIn != '0);
    stat.busHigh   = (busIn == '1);
  end

endmodule

// File: rtl/hdlink_core.sv
`timescale 1ns/1ps
module hdlink_core
  import hdlink_pkg::*;
#(
  parameter bit IS_MASTER  = 1'b1,
  parameter int SIZE_W     = 5,
  parameter int WORD_BYTES = 4,
  parameter int MAX_BYTES  = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic [7:0]       txData,
  output logic             txReady,
  output logic             rxValid,
  output logic [7:0]       rxData,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe
);

  ctlStrobe_t strobe;
  dpStatus_t  stat;
  linkState_t linkState;

  hdlink_ctrl #(
    .IS_MASTER(IS_MASTER)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txValid  (txValid),
    .stat     (stat),
    .strobe   (strobe),
    .txReady  (txReady),
    .linkState(linkState)
  );

  hdlink_dpath #(
    .SIZE_W    (SIZE_W),
    .WORD_BYTES(WORD_BYTES),
    .MAX_BYTES (MAX_BYTES)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .txData (txData),
    .busIn  (busIn),
    .busOut (busOut),
    .busOe  (busOe),
    .rxValid(rxValid),
    .rxData (rxData),
    .stat   (stat)
  );

endmodule

// File: rtl/hdlink_checker.sv
`timescale 1ns/1ps
module hdlink_checker
  import hdlink_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input linkState_t       linkState,
  input logic             busOe,
  input logic [BUS_W-1:0] busOut,
  input logic             txReady,
  input logic             rxValid
);

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_INIT) |-> (!busOe && !txReady && !rxValid));

  p_init_role_r1: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_INIT) |=>
      (IS_MASTER ? (linkState == ST_WAIT_TX) : (linkState == ST_WAIT_RX)));

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_START) |-> (busOe && busOut == '0 && txReady));

  p_start_to_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_START) |=> (linkState == ST_SEND));

  p_fetch_drives_r3: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> busOe);

  p_ta1_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_TA1) |-> (busOe && busOut == '1));

  p_ta1_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_TA1) |=> (linkState == ST_TA2 && !busOe));

  p_ta2_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_TA2) |=> (linkState == ST_WAIT_RX));

  p_rx_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_WAIT_RX || linkState == ST_RECV) |-> !busOe);

  p_rx_strobe_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !busOe);

  p_ta3_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_TA3) |=> (linkState == ST_TA4 && !busOe));

  p_ta4_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_TA4) |=> (linkState == ST_WAIT_TX && busOe));

  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (linkState == ST_ERR) |-> (!busOe && !rxValid));

endmodule

bind hdlink_core hdlink_checker #(
  .IS_MASTER(IS_MASTER)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .linkState(linkState),
  .busOe    (busOe),
  .busOut   (busOut),
  .txReady  (txReady),
  .rxValid  (rxValid)
);

// File: tb/hdlink_core_bench.sv
`timescale 1ns/1ps
module hdlink_core_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // master instance, size limit reduced so oversize headers exist
  logic       mTxValid = 1'b0;
  logic [7:0] mTxData = '0;
  logic       mTxReady, mRxValid, mBusOe;
  logic [7:0] mRxData;
  logic [3:0] mBusOut, mBusIn;
  logic       bOe = 1'b0;
  logic [3:0] bNib = 4'hF;
  assign mBusIn = mBusOe ? mBusOut : (bOe ? bNib : 4'hF);

  hdlink_core #(.IS_MASTER(1'b1), .MAX_BYTES(96)) u_hdlink_core (
    .clk(clk), .rstN(rstN), .txValid(mTxValid), .txData(mTxData), .txReady(mTxReady),
    .rxValid(mRxValid), .rxData(mRxData), .busIn(mBusIn), .busOut(mBusOut), .busOe(mBusOe));

  // slave instance
  logic       sTxValid = 1'b1;
  logic [7:0] sTxData = 8'h00;
  logic       sTxReady, sRxValid, sBusOe;
  logic [7:0] sRxData;
  logic [3:0] sBusOut, sBusIn;
  logic       sbOe = 1'b0;
  logic [3:0] sbNib = 4'hF;
  assign sBusIn = sBusOe ? sBusOut : (sbOe ? sbNib : 4'hF);

  hdlink_core #(.IS_MASTER(1'b0), .MAX_BYTES(96)) u_hdlink_slave (
    .clk(clk), .rstN(rstN), .txValid(sTxValid), .txData(sTxData), .txReady(sTxReady),
    .rxValid(sRxValid), .rxData(sRxData), .busIn(sBusIn), .busOut(sBusOut), .busOe(sBusOe));

  int contention = 0;
  int slaveEarly = 0;
  bit slavePhase = 1'b0;
  always @(negedge clk) begin
    #1;
    if (mBusOe && bOe) contention++;
    if (sBusOe && sbOe) contention++;
    if (rstN && !slavePhase && sBusOe) slaveEarly++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pktByte(input int sz, input int seed, input int i);
    if (i == 0) return {3'(seed), 5'(sz)};
    return 8'(seed * 29 + i * 53 + 1);
  endfunction

  // master sends one packet; starts at a negedge with the core waiting to send
  task automatic sendPkt(input int sz, input int seed);
    int n = (sz + 1) * 4;
    int idx = 0;
    int nibErr = 0, firstAct = 0, firstExp = 0, readyCnt = 0, readyErr = 0;
    bit seen = 1'b0;
    bit took;
    logic [3:0] expNib;
    mTxData  = pktByte(sz, seed, 0);
    mTxValid = 1'b1;
    for (int w = 0; w < 8 && !seen; w++) begin
      @(negedge clk);
      seen = mBusOe && (mBusOut == 4'h0);
    end
    check(seen && mTxReady, "R2", "start marker with header fetch",
          int'({mBusOe, mBusOut, mTxReady}), 33);
    took = mTxReady;
    for (int k = 0; k < 2 * n; k++) begin
      @(negedge clk);
      if (took && idx < n - 1) idx++;
      mTxData = pktByte(sz, seed, idx);
      expNib = ((k % 2) != 0) ? pktByte(sz, seed, k / 2)[7:4] : pktByte(sz, seed, k / 2)[3:0];
      if (!(mBusOe && mBusOut == expNib)) begin
        if (nibErr == 0) begin firstAct = mBusOut; firstExp = expNib; end
        nibErr++;
      end
      if (mTxReady != (((k % 2) != 0) && (k / 2 < n - 1))) readyErr++;
      if (mTxReady) readyCnt++;
      took = mTxReady;
    end
    mTxValid = 1'b0;
    check(nibErr == 0, "R3", "nibble stream order", firstAct, firstExp);
    check(readyErr == 0 && readyCnt == n - 1, "R3", "byte fetch strobes", readyCnt, n - 1);
    @(negedge clk);
    check(mBusOe && mBusOut == 4'hF, "R4", "ones right after sized packet",
          int'({mBusOe, mBusOut}), 31);
    @(negedge clk);
    check(!mBusOe, "R5", "release in second turnaround", mBusOe, 0);
    @(negedge clk);
    check(!mBusOe, "R5", "stays released waiting to receive", mBusOe, 0);
  endtask

  // bench sends one packet to the master; starts at a negedge with the core waiting to receive
  task automatic recvPkt(input int sz, input int seed);
    int n = (sz + 1) * 4;
    int got = 0, dataErr = 0, timeErr = 0, oeErr = 0;
    bOe  = 1'b1;
    bNib = 4'h0;
    for (int k = 0; k < 2 * n; k++) begin
      @(negedge clk);
      if (mRxValid != (k >= 2 && (k % 2) == 0)) timeErr++;
      if (mRxValid) begin
        if (got < n && mRxData != pktByte(sz, seed, got)) dataErr++;
        got++;
      end
      if (mBusOe) oeErr++;
      bNib = ((k % 2) != 0) ? pktByte(sz, seed, k / 2)[7:4] : pktByte(sz, seed, k / 2)[3:0];
    end
    @(negedge clk);
    if (!mRxValid) timeErr++;
    else begin
      if (got < n && mRxData != pktByte(sz, seed, got)) dataErr++;
      got++;
    end
    bOe = 1'b0;
    check(!mBusOe, "R8", "first receive turnaround released", mBusOe, 0);
    @(negedge clk);
    check(!mBusOe && !mRxValid, "R8", "second receive turnaround released",
          int'({mBusOe, mRxValid}), 0);
    @(negedge clk);
    check(mBusOe && mBusOut == 4'hF, "R8", "drives ones after turnaround",
          int'({mBusOe, mBusOut}), 31);
    check(got == n && oeErr == 0, "R6", "bytes received after drop", got, n);
    check(dataErr == 0, "R7", "received byte values", dataErr, 0);
    check(timeErr == 0, "R7", "rxValid pulse timing", timeErr, 0);
  endtask

  task automatic badStart();
    int bad = 0;
    bOe  = 1'b1;
    bNib = 4'h3;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (mBusOe || mRxValid) bad++;
    end
    check(bad == 0, "R9", "silent after partial start", bad, 0);
    bOe = 1'b0;
    @(negedge clk);
    check(!mBusOe, "R9", "reset step after bus idle", mBusOe, 0);
    @(negedge clk);
    check(mBusOe && mBusOut == 4'hF, "R9", "master role resumed",
          int'({mBusOe, mBusOut}), 31);
  endtask

  task automatic oversize();
    int bad = 0;
    logic [3:0] seq [0:6];
    seq = '{4'h8, 4'h1, 4'h5, 4'h5, 4'h5, 4'h5, 4'h5};
    bOe  = 1'b1;
    bNib = 4'h0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (mBusOe || mRxValid) bad++;
      bNib = seq[k];
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (mBusOe || mRxValid) bad++;
    end
    check(bad == 0, "R10", "no byte strobe for size 24", bad, 0);
    bOe = 1'b0;
    @(negedge clk);
    check(!mBusOe, "R10", "reset step after oversize", mBusOe, 0);
    @(negedge clk);
    check(mBusOe && mBusOut == 4'hF, "R10", "master role resumed",
          int'({mBusOe, mBusOut}), 31);
  endtask

  task automatic idleHold();
    int bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!(mBusOe && mBusOut == 4'hF && !mTxReady)) bad++;
    end
    check(bad == 0, "R2", "holds ones without offer", bad, 0);
  endtask

  task automatic slaveFirst();
    logic [7:0] hdr [0:3];
    int got = 0, bad = 0;
    hdr = '{8'h40, 8'h11, 8'h22, 8'h33};
    slavePhase = 1'b1;
    check(slaveEarly == 0 && !sBusOe, "R1", "slave silent before first packet", slaveEarly, 0);
    sbOe  = 1'b1;
    sbNib = 4'h0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (sRxValid) begin
        if (sRxData != hdr[got]) bad++;
        got++;
      end
      sbNib = ((k % 2) != 0) ? hdr[k / 2][7:4] : hdr[k / 2][3:0];
    end
    @(negedge clk);
    if (sRxValid) begin
      if (sRxData != hdr[got]) bad++;
      got++;
    end
    sbOe = 1'b0;
    check(got == 4 && bad == 0, "R7", "slave header-only packet", got, 4);
    @(negedge clk);
    check(!sBusOe, "R8", "slave second turnaround", sBusOe, 0);
    @(negedge clk);
    check(sBusOe && sBusOut == 4'hF, "R1", "slave owns bus after first packet",
          int'({sBusOe, sBusOut}), 31);
    @(negedge clk);
    check(sBusOe && sBusOut == 4'h0 && sTxReady, "R2", "slave start marker",
          int'({sBusOe, sBusOut, sTxReady}), 33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!mBusOe && !mTxReady && !mRxValid, "R1", "reset state released",
          int'({mBusOe, mTxReady, mRxValid}), 0);
    @(negedge clk);
    check(mBusOe && mBusOut == 4'hF, "R1", "master drives ones after reset step",
          int'({mBusOe, mBusOut}), 31);
    idleHold();
    sendPkt(0, 1);
    recvPkt(7, 2);
    sendPkt(5, 3);
    recvPkt(0, 4);
    sendPkt(23, 5);
    recvPkt(23, 6);
    sendPkt(0, 7);
    badStart();
    sendPkt(1, 0);
    oversize();
    idleHold();
    sendPkt(2, 6);
    recvPkt(3, 3);
    slaveFirst();
    check(contention == 0, "R5", "no simultaneous drive", contention, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule